// File: doc/BRIEF.md
# Delayed-Copy Signal Checker

This block watches two single-bit signals on one clock: a reference and a follower. The follower should be the reference shifted later by a whole number of cycles, with no other change in shape. The lag is not known in advance. The block measures it from the first rising edge of the reference to the first rising edge of the follower and stores it. It then sets a locked flag and starts checking.

After lock, the block delays the reference by the learned lag and compares the follower against that delayed stream. It checks the edges of each polarity and the lengths of the high and low runs. Each kind of fault has its own sticky flag, and one combined error output summarises them.

The block can sit beside any single-bit path whose latency is fixed but unknown, such as a pipeline-delayed valid or a retimed strobe. Its flags can then be watched from a bench or from on-chip debug logic.

Top module: `delay_copy_checker`

## Requirements
- R1: A synchronous active-high reset clears the lag to 0, the locked flag and every error flag. Both inputs are treated as having been low before the first cycle after reset.
- R2: The lag is the number of cycles from the cycle in which the reference first rises to the cycle in which the follower first rises. It ranges from 0 to MAX_LAG. `locked_o` goes high on the clock edge that ends the follower-rise cycle.
- R3: Once locked, the lag value and the locked flag hold until reset.
- R4: While not locked, the edge, high-run and low-run flags stay clear, whatever the inputs do.
- R5: After lock, each rise or fall of the reference must appear as a follower edge of the same polarity exactly lag cycles later. A follower edge with no such reference edge is also a fault. Any such fault sets `err_edge_o`.
- R6: After lock, if the length of a follower high run differs from that of the matching delayed-reference high run, `err_high_o` is set.
- R7: After lock, if the length of a follower low run differs from that of the matching delayed-reference low run, `err_low_o` is set. The low run that precedes lock is not compared.
- R8: The block counts reference rises not yet answered by a follower rise. A follower rise while this count is zero, and with no reference rise in the same cycle, sets `err_orphan_o`.
- R9: If the follower has not risen MAX_LAG cycles after the first reference rise, `err_timeout_o` is set on that clock edge and `locked_o` stays low until reset.
- R10: With a learned lag of 0, any cycle after lock in which the follower differs from the reference sets `err_edge_o`.
- R11: All error flags are sticky until reset. `err_o` is high exactly when any of the five error flags is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference signal |
| fol_i | input | 1 | Follower signal, expected to be a delayed copy of ref_i |
| lag_o | output | $clog2(MAX_LAG+1) | Learned lag in cycles |
| locked_o | output | 1 | Lag learned, checking active |
| err_edge_o | output | 1 | Sticky: follower edge timing or polarity mismatch |
| err_high_o | output | 1 | Sticky: high run length mismatch |
| err_low_o | output | 1 | Sticky: low run length mismatch |
| err_orphan_o | output | 1 | Sticky: follower rise with no pending reference rise |
| err_timeout_o | output | 1 | Sticky: first follower rise missing within MAX_LAG cycles |
| err_o | output | 1 | OR of all error flags |

## Verification
The reference waveform has irregular run lengths of 2 to 6 cycles, so a checker that only compares a fixed pulse width cannot pass it. The bench drives it with a clean copy at lags 5, 0 and MAX_LAG, which must give no error at all. Two faulty copies then add a single extra cycle, one inside a high run and one inside a low run, with the rest of the wave shifted. These show that the high and low length checks are separate, since only one of the two flags may fire while the edge check fires in both. A single-cycle glitch at lag 0, a follower pulse before any reference activity, and a follower that never rises cover the per-cycle equality, the unmatched-pulse and the timeout paths.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_COUNT,
        LS_LOCKED,
        LS_TIMEOUT
    } learn_state_e;

endpackage

// File: rtl/dcc_lag_learner.sv
module dcc_lag_learner
    import dcc_pkg::*;
#(
    parameter int MAX_LAG = 255,
    parameter int LAG_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise_i,
    input  logic             fol_rise_i,
    output logic [LAG_W-1:0] lag_o,
    output logic             locked_o,
    output logic             lock_now_o,
    output logic             timeout_o
);

    typedef struct packed {
        learn_state_e     state;
        logic [LAG_W-1:0] cnt;
        logic [LAG_W-1:0] lag;
    } learn_t;

    learn_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        lock_now_o = 1'b0;
        unique case (s_q.state)
            LS_IDLE: begin
                if (ref_rise_i) begin
                    if (fol_rise_i) begin
                        s_d.lag    = '0;
                        s_d.state  = LS_LOCKED;
                        lock_now_o = 1'b1;
                    end else begin
                        s_d.cnt   = LAG_W'(1);
                        s_d.state = LS_COUNT;
                    end
                end
            end
            LS_COUNT: begin
                if (fol_rise_i) begin
                    s_d.lag    = s_q.cnt;
                    s_d.state  = LS_LOCKED;
                    lock_now_o = 1'b1;
                end else if (s_q.cnt == LAG_W'(MAX_LAG)) begin
                    s_d.state = LS_TIMEOUT;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{state: LS_IDLE, cnt: '0, lag: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign lag_o     = s_q.lag;
    assign locked_o  = (s_q.state == LS_LOCKED);
    assign timeout_o = (s_q.state == LS_TIMEOUT);

endmodule

// File: rtl/dcc_ref_delay.sv
module dcc_ref_delay #(
    parameter int MAX_LAG = 255,
    parameter int LAG_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_i,
    input  logic [LAG_W-1:0] lag_i,
    output logic             dref_o,
    output logic             dref_prev_o,
    output logic             ref_prev_o
);

    // hist_q[k] holds the reference value from k+1 cycles ago
    logic [MAX_LAG:0] hist_d, hist_q;

    always_comb begin
        hist_d = {hist_q[MAX_LAG-1:0], ref_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign dref_o      = (lag_i == '0) ? ref_i : hist_q[LAG_W'(lag_i - 1'b1)];
    assign dref_prev_o = hist_q[lag_i];
    assign ref_prev_o  = hist_q[0];

endmodule

// File: rtl/dcc_run_compare.sv
module dcc_run_compare #(
    parameter int RUN_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic active_i,
    input  logic d_i,
    input  logic d_prev_i,
    input  logic f_i,
    input  logic f_prev_i,
    output logic hi_mis_o,
    output logic lo_mis_o
);

    // index 1 tracks high runs, index 0 tracks low runs
    typedef struct packed {
        logic [RUN_W-1:0]            dcnt;
        logic [RUN_W-1:0]            fcnt;
        logic [1:0][RUN_W-1:0]       dlen;
        logic [1:0][RUN_W-1:0]       flen;
        logic [1:0]                  dv;
        logic [1:0]                  fv;
    } run_t;

    run_t r_d, r_q;
    logic [1:0] mis;

    always_comb begin
        logic d_edge, f_edge;
        r_d    = r_q;
        mis    = '0;
        d_edge = d_i ^ d_prev_i;
        f_edge = f_i ^ f_prev_i;
        if (start_i) begin
            r_d.dcnt = RUN_W'(1);
            r_d.fcnt = RUN_W'(1);
            r_d.dv   = '0;
            r_d.fv   = '0;
        end else if (active_i) begin
            r_d.dcnt = d_edge ? RUN_W'(1) : ((&r_q.dcnt) ? r_q.dcnt : r_q.dcnt + 1'b1);
            r_d.fcnt = f_edge ? RUN_W'(1) : ((&r_q.fcnt) ? r_q.fcnt : r_q.fcnt + 1'b1);
            for (int p = 0; p < 2; p++) begin
                if (d_edge && (d_prev_i == p[0])) begin
                    r_d.dlen[p] = r_q.dcnt;
                    r_d.dv[p]   = 1'b1;
                end
                if (f_edge && (f_prev_i == p[0])) begin
                    r_d.flen[p] = r_q.fcnt;
                    r_d.fv[p]   = 1'b1;
                end
                if (r_d.dv[p] && r_d.fv[p]) begin
                    mis[p]    = (r_d.dlen[p] != r_d.flen[p]);
                    r_d.dv[p] = 1'b0;
                    r_d.fv[p] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hi_mis_o = mis[1];
    assign lo_mis_o = mis[0];

endmodule

// File: rtl/delay_copy_checker.sv
module delay_copy_checker #(
    parameter  int MAX_LAG = 255,
    parameter  int RUN_W   = 16,
    localparam int LAG_W   = $clog2(MAX_LAG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_i,
    input  logic             fol_i,
    output logic [LAG_W-1:0] lag_o,
    output logic             locked_o,
    output logic             err_edge_o,
    output logic             err_high_o,
    output logic             err_low_o,
    output logic             err_orphan_o,
    output logic             err_timeout_o,
    output logic             err_o
);

    localparam int PEND_W = LAG_W + 1;

    typedef struct packed {
        logic              fol_prev;
        logic [PEND_W-1:0] pend;
        logic              e_edge;
        logic              e_high;
        logic              e_low;
        logic              e_orph;
    } top_t;

    top_t t_d, t_q;

    logic ref_prev, dref, dref_prev;
    logic lock_now, timeout;
    logic hi_mis, lo_mis;
    logic ref_rise, fol_rise;

    assign ref_rise = ref_i & ~ref_prev;
    assign fol_rise = fol_i & ~t_q.fol_prev;

    dcc_lag_learner #(.MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) u_learn (
        .clk        (clk),
        .rst        (rst),
        .ref_rise_i (ref_rise),
        .fol_rise_i (fol_rise),
        .lag_o      (lag_o),
        .locked_o   (locked_o),
        .lock_now_o (lock_now),
        .timeout_o  (timeout)
    );

    dcc_ref_delay #(.MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) u_delay (
        .clk         (clk),
        .rst         (rst),
        .ref_i       (ref_i),
        .lag_i       (lag_o),
        .dref_o      (dref),
        .dref_prev_o (dref_prev),
        .ref_prev_o  (ref_prev)
    );

    dcc_run_compare #(.RUN_W(RUN_W)) u_runs (
        .clk      (clk),
        .rst      (rst),
        .start_i  (lock_now),
        .active_i (locked_o),
        .d_i      (dref),
        .d_prev_i (dref_prev),
        .f_i      (fol_i),
        .f_prev_i (t_q.fol_prev),
        .hi_mis_o (hi_mis),
        .lo_mis_o (lo_mis)
    );

    always_comb begin
        logic d_rise, d_fall, f_fall;
        t_d          = t_q;
        t_d.fol_prev = fol_i;

        // outstanding reference rises awaiting a follower rise
        unique case ({ref_rise, fol_rise})
            2'b10: if (!(&t_q.pend)) t_d.pend = t_q.pend + 1'b1;
            2'b01: begin
                if (t_q.pend == '0) t_d.e_orph = 1'b1;
                else                t_d.pend   = t_q.pend - 1'b1;
            end
            default: ;
        endcase

        d_rise = dref & ~dref_prev;
        d_fall = ~dref & dref_prev;
        f_fall = ~fol_i & t_q.fol_prev;
        if (locked_o) begin
            if ((d_rise != fol_rise) || (d_fall != f_fall)) t_d.e_edge = 1'b1;
            if (hi_mis) t_d.e_high = 1'b1;
            if (lo_mis) t_d.e_low  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign err_edge_o    = t_q.e_edge;
    assign err_high_o    = t_q.e_high;
    assign err_low_o     = t_q.e_low;
    assign err_orphan_o  = t_q.e_orph;
    assign err_timeout_o = timeout;
    assign err_o         = t_q.e_edge | t_q.e_high | t_q.e_low | t_q.e_orph | timeout;

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
    parameter int MAX_LAG = 255,
    parameter int LAG_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_i,
    input logic             fol_i,
    input logic [LAG_W-1:0] lag_o,
    input logic             locked_o,
    input logic             err_edge_o,
    input logic             err_high_o,
    input logic             err_low_o,
    input logic             err_timeout_o,
    input logic             err_o
);

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> (locked_o && $stable(lag_o)));  // R3

    AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !locked_o |-> !(err_edge_o || err_high_o || err_low_o));  // R4

    AST_TIMEOUT_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        !(locked_o && err_timeout_o));  // R9

    AST_ZERO_LAG_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (locked_o && (lag_o == '0) && (fol_i != ref_i)) |=> err_edge_o);  // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);  // R11

    AST_LAG_RANGE: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> (int'(lag_o) <= MAX_LAG));  // R2

endmodule

bind delay_copy_checker dcc_checker #(.MAX_LAG(MAX_LAG), .LAG_W(LAG_W)) u_dcc_chk (
    .clk           (clk),
    .rst           (rst),
    .ref_i         (ref_i),
    .fol_i         (fol_i),
    .lag_o         (lag_o),
    .locked_o      (locked_o),
    .err_edge_o    (err_edge_o),
    .err_high_o    (err_high_o),
    .err_low_o     (err_low_o),
    .err_timeout_o (err_timeout_o),
    .err_o         (err_o)
);

// File: tb/tb_delay_copy_checker.sv
`timescale 1ns/1ps
module tb_delay_copy_checker;

    localparam int MAX_LAG = 255;
    localparam int LAG_W   = $clog2(MAX_LAG + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ref_i = 1'b0;
    logic             fol_i = 1'b0;
    logic [LAG_W-1:0] lag_o;
    logic             locked_o, err_edge_o, err_high_o, err_low_o;
    logic             err_orphan_o, err_timeout_o, err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    delay_copy_checker #(.MAX_LAG(MAX_LAG)) dut (
        .clk           (clk),
        .rst           (rst),
        .ref_i         (ref_i),
        .fol_i         (fol_i),
        .lag_o         (lag_o),
        .locked_o      (locked_o),
        .err_edge_o    (err_edge_o),
        .err_high_o    (err_high_o),
        .err_low_o     (err_low_o),
        .err_orphan_o  (err_orphan_o),
        .err_timeout_o (err_timeout_o),
        .err_o         (err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // reference: runs of 4,3,2,5,4,2,6,3 cycles, starting low, period 29
    function automatic logic wave(input int i);
        int lens[8];
        int pos;
        int k;
        lens = '{4, 3, 2, 5, 4, 2, 6, 3};
        pos  = i % 29;
        k    = 0;
        while (pos >= lens[k]) begin
            pos -= lens[k];
            k++;
        end
        return k[0];
    endfunction

    // kind 1: one extra high cycle at 11; kind 2: one extra low cycle at 16;
    // kind 3: one-cycle inversion at 40; otherwise an exact copy
    function automatic logic fwave(input int kind, input int j);
        case (kind)
            1:       return wave(j < 11 ? j : j - 1);
            2:       return wave(j < 16 ? j : j - 1);
            3:       return wave(j) ^ (j == 40);
            default: return wave(j);
        endcase
    endfunction

    task automatic step(input logic r, input logic f);
        ref_i = r;
        fol_i = f;
        @(negedge clk);
    endtask

    task automatic run_wave(input int lag, input int kind, input int from, input int to);
        for (int i = from; i < to; i++) begin
            step(wave(i), (i >= lag) ? fwave(kind, i - lag) : 1'b0);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(0, 0);
        step(0, 0);
        step(0, 0);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 lag", int'(lag_o), 0);
        check("R1 locked", int'(locked_o), 0);
        check("R1 err", int'({err_edge_o, err_high_o, err_low_o, err_orphan_o, err_timeout_o, err_o}), 0);
    endtask

    task automatic t_clean_lag5();
        do_reset();
        run_wave(5, 0, 0, 9);
        check("R2 not locked before follower rise", int'(locked_o), 0);
        run_wave(5, 0, 9, 10);
        check("R2 locked", int'(locked_o), 1);
        check("R2 lag", int'(lag_o), 5);
        run_wave(5, 0, 10, 130);
        check("R3 lag held", int'(lag_o), 5);
        check("R3 locked held", int'(locked_o), 1);
        check("R5 clean edges", int'(err_edge_o), 0);
        check("R6 clean highs", int'(err_high_o), 0);
        check("R7 clean lows", int'(err_low_o), 0);
        check("R8 no orphan", int'(err_orphan_o), 0);
        check("R11 err clear", int'(err_o), 0);
    endtask

    task automatic t_zero_lag();
        do_reset();
        run_wave(0, 3, 0, 5);
        check("R2 lag0 locked", int'(locked_o), 1);
        check("R2 lag0 value", int'(lag_o), 0);
        run_wave(0, 3, 5, 40);
        check("R10 equal so far", int'(err_edge_o), 0);
        run_wave(0, 3, 40, 41);
        check("R10 glitch flagged", int'(err_edge_o), 1);
        run_wave(0, 3, 41, 70);
        check("R11 edge sticky", int'(err_edge_o), 1);
        check("R11 err or", int'(err_o), 1);
    endtask

    task automatic t_long_high();
        do_reset();
        run_wave(3, 1, 0, 120);
        check("R5 shifted edge", int'(err_edge_o), 1);
        check("R6 high length", int'(err_high_o), 1);
        check("R7 low intact", int'(err_low_o), 0);
        check("R8 no orphan", int'(err_orphan_o), 0);
    endtask

    task automatic t_long_low();
        do_reset();
        run_wave(3, 2, 0, 120);
        check("R5 shifted edge", int'(err_edge_o), 1);
        check("R7 low length", int'(err_low_o), 1);
        check("R6 high intact", int'(err_high_o), 0);
        check("R11 err or", int'(err_o), 1);
    endtask

    task automatic t_orphan();
        do_reset();
        step(0, 0);
        step(0, 1);
        check("R8 orphan rise", int'(err_orphan_o), 1);
        step(0, 1);
        step(0, 0);
        step(0, 1);
        step(0, 0);
        check("R4 no edge before lock", int'(err_edge_o), 0);
        check("R4 no runs before lock", int'(err_high_o | err_low_o), 0);
        check("R4 not locked", int'(locked_o), 0);
        check("R11 err or", int'(err_o), 1);
    endtask

    task automatic t_timeout();
        do_reset();
        for (int i = 0; i < 300; i++) begin
            step(i >= 2, 0);
            if (i == 256) check("R9 no timeout yet", int'(err_timeout_o), 0);
            if (i == 257) check("R9 timeout", int'(err_timeout_o), 1);
        end
        check("R9 stays unlocked", int'(locked_o), 0);
        check("R11 timeout in err", int'(err_o), 1);
    endtask

    task automatic t_max_lag();
        do_reset();
        run_wave(MAX_LAG, 0, 0, 4 + MAX_LAG);
        check("R2 max lag not yet", int'(locked_o), 0);
        run_wave(MAX_LAG, 0, 4 + MAX_LAG, 5 + MAX_LAG);
        check("R2 max lag locked", int'(locked_o), 1);
        check("R2 max lag value", int'(lag_o), MAX_LAG);
        run_wave(MAX_LAG, 0, 5 + MAX_LAG, 5 + MAX_LAG + 90);
        check("R5 max lag clean", int'(err_o), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_clean_lag5();
        t_zero_lag();
        t_long_high();
        t_long_low();
        t_orphan();
        t_timeout();
        t_max_lag();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule